// File: doc/BRIEF.md
# Custom Instruction Conversion Unit

This block sits in the coprocessor slot of a RISC-V style core and executes register-to-register custom instructions. For each instruction the core hands over two 32-bit source operands (A from rs1, B from rs2), the 3-bit funct3 field and the 7-bit funct7 field, and pulses a start strobe. The unit picks one of four bit-level conversions by funct3, registers the 32-bit answer and raises a one-cycle done pulse on the next clock edge.

No encoding is ever refused. The four upper funct3 codes complete in the same way and return zero. The funct7 field is accepted but changes nothing. A new start may arrive in the very cycle a previous answer is being returned, so the core can issue one instruction per cycle.

The reset input is asynchronous and active-low. Its release is synchronised inside the block, so the block comes out of reset two clock edges after the input rises.

Top module: `cfu_conv_unit`

## Requirements
- R1: With funct3 = 3'b000 the captured result is the Gray code of A, that is A XOR (A shifted right by one), and B has no effect.
- R2: With funct3 = 3'b001 the captured result is the binary value of Gray-coded A: result bit i is the XOR of A bits 31 down to i. B has no effect.
- R3: With funct3 = 3'b010 the captured result is A with its bit order mirrored (result bit i = A bit 31-i), and B has no effect.
- R4: With funct3 = 3'b011 the captured result is the bitwise XNOR of A and B.
- R5: With funct3[2] = 1 (codes 3'b100 to 3'b111) the operation completes with a done pulse and a result of all zeros.
- R6: The funct7 field has no effect on the result or on the timing of any operation.
- R7: For funct3 codes 3'b000, 3'b001 and 3'b010, changing B leaves the result unchanged.
- R8: done is high in a cycle exactly when start was sampled high at the previous clock edge. It gives one pulse per start, including for starts on consecutive cycles.
- R9: In cycles where start was low at the previous edge, the result output keeps its value.
- R10: While reset is low, result is zero and done is low. After a reset during operation, result reads zero until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Operation request; the operands and fields are sampled on this edge |
| funct3_i | input | 3 | Operation select |
| funct7_i | input | 7 | Immediate field, accepted and ignored |
| opa_i | input | 32 | Operand A (from rs1) |
| opb_i | input | 32 | Operand B (from rs2) |
| result_o | output | 32 | Registered result of the last operation |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check, on every cycle, that done follows start by exactly one edge, that the result holds while no operation is captured, and that the zero-result, Gray-encode and XNOR operations return the right value from the sampled operands. They also check that the outputs are clear while reset is held. The bench's reference model covers what a per-cycle property does not express: the prefix-XOR decode and mirror operations over many operand patterns, the invariance to funct7 and to B, streams of back-to-back starts, and a reset issued in the middle of operation.

// File: rtl/cfu_conv_pkg.sv
package cfu_conv_pkg;

  localparam int unsigned OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_GRAY_ENC = 3'd0,
    OP_GRAY_DEC = 3'd1,
    OP_MIRROR   = 3'd2,
    OP_XNOR     = 3'd3,
    OP_ZERO     = 3'd4
  } cfu_op_e;

endpackage

// File: rtl/cfu_rst_sync.sv
module cfu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/cfu_op_decode.sv
module cfu_op_decode
  import cfu_conv_pkg::*;
(
  input  logic [2:0] funct3_i,
  output cfu_op_e    op_o
);

  always_comb begin
    if (funct3_i[2]) begin
      op_o = OP_ZERO;
    end else begin
      unique case (funct3_i[1:0])
        2'b00:   op_o = OP_GRAY_ENC;
        2'b01:   op_o = OP_GRAY_DEC;
        2'b10:   op_o = OP_MIRROR;
        default: op_o = OP_XNOR;
      endcase
    end
  end

endmodule

// File: rtl/cfu_conv_datapath.sv
module cfu_conv_datapath
  import cfu_conv_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  cfu_op_e         op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] res_o
);

  localparam int unsigned MSB = XLEN - 1;

  logic [XLEN-1:0] gray_enc;
  logic [XLEN-1:0] gray_dec;
  logic [XLEN-1:0] mirror;
  logic [XLEN-1:0] xnor_v;

  assign gray_enc = opa_i ^ (opa_i >> 1);
  assign xnor_v   = ~(opa_i ^ opb_i);

  // Prefix XOR running from the top bit downward
  assign gray_dec[MSB] = opa_i[MSB];

  for (genvar gi = 0; gi < MSB; gi++) begin : g_dec
    assign gray_dec[gi] = gray_dec[gi+1] ^ opa_i[gi];
  end

  for (genvar gi = 0; gi < XLEN; gi++) begin : g_mir
    assign mirror[gi] = opa_i[MSB-gi];
  end

  always_comb begin
    unique case (op_i)
      OP_GRAY_ENC: res_o = gray_enc;
      OP_GRAY_DEC: res_o = gray_dec;
      OP_MIRROR:   res_o = mirror;
      OP_XNOR:     res_o = xnor_v;
      default:     res_o = '0;
    endcase
  end

endmodule

// File: rtl/cfu_conv_unit.sv
module cfu_conv_unit
  import cfu_conv_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      funct3_i,
  input  logic [6:0]      funct7_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] result_o,
  output logic            done_o
);

  logic            rst_sync_n;
  cfu_op_e         op_sel;
  logic [XLEN-1:0] dp_res;

  logic [XLEN-1:0] result_d, result_q;
  logic            done_d, done_q;
  logic            result_en;

  // funct7 is part of the instruction format but selects nothing here
  logic unused_funct7;
  assign unused_funct7 = ^funct7_i;

  cfu_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  cfu_op_decode u_decode (
    .funct3_i (funct3_i),
    .op_o     (op_sel)
  );

  cfu_conv_datapath #(
    .XLEN (XLEN)
  ) u_datapath (
    .op_i  (op_sel),
    .opa_i (opa_i),
    .opb_i (opb_i),
    .res_o (dp_res)
  );

  // Next-state logic
  always_comb begin
    result_en = start_i;
    result_d  = result_q;
    if (result_en) begin
      result_d = dp_res;
    end
    done_d = start_i;
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      result_q <= result_d;
      done_q   <= done_d;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

endmodule

// File: rtl/cfu_conv_unit_chk.sv
module cfu_conv_unit_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [2:0]      funct3_i,
  input logic [XLEN-1:0] opa_i,
  input logic [XLEN-1:0] opb_i,
  input logic [XLEN-1:0] result_o,
  input logic            done_o
);

  logic rst_seen;
  always_ff @(posedge clk_i) begin
    rst_seen <= !rst_ni;
  end

  // R10
  always @(posedge clk_i) begin
    if (!rst_ni && rst_seen) begin
      reset_clear_chk: assert (done_o == 1'b0 && result_o == '0)
        else $error("outputs not clear in reset");
    end
  end

  // R8
  done_follows_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (done_o == $past(start_i)));

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(start_i)) |-> $stable(result_o));

  // R5
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(start_i) && $past(funct3_i[2])) |-> (result_o == '0));

  // R1
  gray_enc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(start_i) && ($past(funct3_i) == 3'b000))
      |-> (result_o == ($past(opa_i) ^ ($past(opa_i) >> 1))));

  // R4
  xnor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(start_i) && ($past(funct3_i) == 3'b011))
      |-> (result_o == ~($past(opa_i) ^ $past(opb_i))));

endmodule

bind cfu_conv_unit cfu_conv_unit_chk #(
  .XLEN (XLEN)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_sync_n),
  .start_i  (start_i),
  .funct3_i (funct3_i),
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .result_o (result_o),
  .done_o   (done_o)
);

// File: tb/cfu_conv_unit_tb.sv
module cfu_conv_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  funct3;
  logic [6:0]  funct7;
  logic [31:0] opa, opb;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended  = 0;

  logic [31:0] prng = 32'd271828183;

  // Reference model state
  logic [31:0] exp_res;
  logic        exp_done;
  string       exp_tag;
  logic        rst_prev;

  cfu_conv_unit u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .funct3_i (funct3),
    .funct7_i (funct7),
    .opa_i    (opa),
    .opb_i    (opb),
    .result_o (result),
    .done_o   (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] next_rand();
    prng = prng ^ (prng << 13);
    prng = prng ^ (prng >> 17);
    prng = prng ^ (prng << 5);
    return prng;
  endfunction

  function automatic logic [31:0] ref_fn(input logic [2:0] f3, input logic [31:0] a,
                                         input logic [31:0] b);
    logic [31:0] r;
    r = '0;
    case (f3)
      3'd0: r = a ^ (a >> 1);
      3'd1: for (int i = 0; i < 32; i++) r[i] = ^(a >> i);
      3'd2: for (int i = 0; i < 32; i++) r[i] = a[31-i];
      3'd3: r = ~(a ^ b);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] f3);
    case (f3)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // Model updates at each edge, in cycle terms
  always @(posedge clk) begin
    rst_prev <= rst_n;
    if (!rst_n) begin
      exp_res  = '0;
      exp_done = 1'b0;
      exp_tag  = "R10";
    end else begin
      exp_done = start;
      if (start) begin
        exp_res = ref_fn(funct3, opa, opb);
        exp_tag = tag_of(funct3);
      end else begin
        exp_tag = "R9";
      end
    end
  end

  // Compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && rst_prev) begin
      check("R8", {31'd0, done}, {31'd0, exp_done}, "done vs model");
      check(exp_tag, result, exp_res, "result vs model");
    end
  end

  task automatic do_op(input logic [2:0] f3, input logic [6:0] f7, input logic [31:0] a,
                       input logic [31:0] b, output logic [31:0] r);
    @(negedge clk);
    start = 1'b1; funct3 = f3; funct7 = f7; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    r = result;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] r0, r1, a;
    rst_n = 1'b0; start = 1'b0; funct3 = '0; funct7 = '0; opa = '0; opb = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10", result, 32'h0, "result in reset");
    check("R10", {31'd0, done}, 32'h0, "done in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1..R5 with random operands and random funct7 (R6)
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < 6; k++) begin
        a = next_rand();
        do_op(3'(f), 7'(next_rand()), a, next_rand(), r0);
        check(tag_of(3'(f)), r0, ref_fn(3'(f), a, 32'h0 ^ opb), "single op");
        @(negedge clk);
      end
    end

    // Corner values
    do_op(3'd0, 7'h00, 32'hFFFF_FFFF, 32'h0, r0);
    check("R1", r0, 32'h8000_0000, "gray of all ones");
    do_op(3'd1, 7'h00, 32'h8000_0000, 32'h0, r0);
    check("R2", r0, 32'hFFFF_FFFF, "decode of top bit");
    do_op(3'd1, 7'h00, 32'h0000_0001, 32'h0, r0);
    check("R2", r0, 32'h0000_0001, "decode of low bit");
    do_op(3'd2, 7'h7F, 32'h0000_0001, 32'h0, r0);
    check("R3", r0, 32'h8000_0000, "mirror of bit 0");
    do_op(3'd3, 7'h00, 32'hA5A5_0F0F, 32'hA5A5_0F0F, r0);
    check("R4", r0, 32'hFFFF_FFFF, "xnor of equal operands");
    do_op(3'd7, 7'h7F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, r0);
    check("R5", r0, 32'h0, "upper code returns zero");

    // R6: funct7 invariance
    for (int f = 0; f < 4; f++) begin
      a = next_rand();
      do_op(3'(f), 7'h00, a, 32'h1234_5678, r0);
      do_op(3'(f), 7'h7F, a, 32'h1234_5678, r1);
      check("R6", r1, r0, "funct7 changed the result");
    end

    // R7: B ignored for the single-operand codes
    for (int f = 0; f < 3; f++) begin
      a = next_rand();
      do_op(3'(f), 7'h00, a, 32'h0, r0);
      do_op(3'(f), 7'h00, a, 32'hFFFF_FFFF, r1);
      check("R7", r1, r0, "operand B changed the result");
    end

    // R8: back-to-back starts, model compares each cycle
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      start = 1'b1; funct3 = 3'(k); funct7 = 7'(k); opa = next_rand(); opb = next_rand();
      @(negedge clk);
    end
    start = 1'b0;
    // R9: idle cycles hold the last result
    repeat (5) @(negedge clk);

    // R10: reset in the middle of operation
    do_op(3'd3, 7'h00, 32'h0, 32'h1, r0);
    check("R10", r0, 32'hFFFF_FFFE, "value before reset");
    #2 rst_n = 1'b0;
    @(negedge clk);
    check("R10", result, 32'h0, "result after mid-run reset");
    check("R10", {31'd0, done}, 32'h0, "done after mid-run reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10", result, 32'h0, "result stays clear until start");
    do_op(3'd2, 7'h00, 32'h0000_0003, 32'h0, r0);
    check("R3", r0, 32'hC000_0000, "mirror after reset");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule